// File: doc/BRIEF.md
# Switch Memory Initialisation and Selftest Sequencer

This block prepares the memories of a time-slot switch before traffic is enabled. On command it sweeps the connection memory and sets the tristate-control bit of every entry, so no output drives data from an entry that was never programmed. On another command it runs a built-in selftest over one half of the data memory. Each procedure runs for a fixed number of clock cycles. The block raises a busy flag while it runs and fires a one-cycle completion interrupt at the end. A selftest also records a pass or fail verdict.

Software writes a three-bit procedure code and then waits for the interrupt. A full data-memory test needs two commands, one for each half. Both memories are modelled inside the block as plain synchronous RAMs. The switching datapath reads them through one read port each, and this block brings those ports out. The global output enable is held off whenever the mode enable is clear or a procedure is running.

Top module: `csw_init_seq`

## Requirements
- R1: After reset, busy, irq, irq_sticky, st_ok and out_oe are all 0.
- R2: A code whose two low bits are 01 (001 or 101), written while idle, starts a memory clear. busy is then high for exactly CLR_CYCLES (4096) cycles.
- R3: After a clear, bit CM_W-1 (the tristate bit) of every connection-memory entry reads 1.
- R4: Code 011 or 111, written while idle, starts a selftest. busy is then high for exactly TEST_CYCLES (10240) cycles. Afterwards every connection-memory tristate bit reads 1.
- R5: Code 011 tests the upper half of the data memory (address MSB 1) and code 111 tests the lower half (address MSB 0). Each tested word at address a ends up holding the complement of {a, ~a}. The untested half keeps its contents.
- R6: When a selftest completes, st_ok becomes 1 if every read-back matched and 0 otherwise. A clear leaves st_ok unchanged.
- R7: irq is high for exactly one cycle: the first cycle in which busy is low again. irq_sticky is set in that same cycle.
- R8: irq_sticky is cleared by a status_rd strobe. If the strobe falls in the cycle in which an operation completes, the set wins.
- R9: A command written while busy is ignored, and the running operation's length is unchanged. Codes 000, 010, 100 and 110 start nothing.
- R10: out_oe is 1 only when mode_en is 1 and no procedure is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, held for at least two cycles |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 3 | Procedure code |
| status_rd | input | 1 | Status read strobe; clears irq_sticky |
| mode_en | input | 1 | Output enable from the mode register |
| cm_rd_addr | input | CM_AW | Connection-memory read address (one-cycle latency) |
| cm_rd_data | output | CM_W | Connection-memory read data; MSB is the tristate bit |
| dm_rd_addr | input | DM_AW | Data-memory read address (one-cycle latency) |
| dm_rd_data | output | 2*DM_AW | Data-memory read data |
| busy | output | 1 | A procedure is active |
| irq | output | 1 | One-cycle completion pulse |
| irq_sticky | output | 1 | Completion flag held until read |
| st_ok | output | 1 | Verdict of the most recent selftest |
| out_oe | output | 1 | Global output enable for the serial outputs |

## Verification
The failing selftest is the hardest case to reach from the ports. A working RAM always returns what was written, so st_ok never drops on its own. To reach that case, the bench forces the data-memory read path feeding the comparator to zero for the length of one lower-half test. Every written pattern and its complement are non-zero, so each read-back mismatches. After the forced test, a later clear must leave the 0 verdict in place, and an unforced test must restore it to 1. The half selection is checked by taking a snapshot of the whole data memory through its read port before each test and comparing afterwards.

// File: rtl/csw_init_pkg.sv
package csw_init_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_TEST_UP = 2'd2,
    OP_TEST_LO = 2'd3
  } op_e;

  // Low bits 01 select a clear; 011 and 111 select a half-memory test.
  function automatic op_e decode_cmd(input logic [2:0] code);
    if (code[1:0] == 2'b01)  return OP_CLEAR;
    else if (code == 3'b011) return OP_TEST_UP;
    else if (code == 3'b111) return OP_TEST_LO;
    else                     return OP_IDLE;
  endfunction

  function automatic logic is_test(input op_e op);
    return (op == OP_TEST_UP) || (op == OP_TEST_LO);
  endfunction

endpackage

// File: rtl/csw_sync_ram.sv
module csw_sync_ram #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NRP = 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRP-1:0][AW-1:0]  raddr,
  output logic [NRP-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/csw_seq_ctrl.sv
module csw_seq_ctrl
  import csw_init_pkg::*;
#(
  parameter int CLR_CYCLES  = 4096,
  parameter int TEST_CYCLES = 10240,
  parameter int CW          = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [2:0]    cmd_code,
  input  logic          status_rd,
  input  logic          test_fail,
  output logic          start,
  output logic          done,
  output logic          busy,
  output op_e           op,
  output logic [CW-1:0] cnt,
  output logic          irq,
  output logic          irq_sticky,
  output logic          st_ok
);
  op_e req_op;

  function automatic logic [CW-1:0] last_count(input op_e o);
    return is_test(o) ? CW'(TEST_CYCLES - 1) : CW'(CLR_CYCLES - 1);
  endfunction

  assign req_op = decode_cmd(cmd_code);
  assign start  = cmd_we && !busy && (req_op != OP_IDLE);
  assign done   = busy && (cnt == last_count(op));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op   <= OP_IDLE;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      op   <= req_op;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) begin
        busy <= 1'b0;
        op   <= OP_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      irq_sticky <= 1'b0;
      st_ok      <= 1'b0;
    end else begin
      irq <= done;
      if (done)           irq_sticky <= 1'b1;
      else if (status_rd) irq_sticky <= 1'b0;
      if (done && is_test(op)) st_ok <= !test_fail;
    end
  end

endmodule

// File: rtl/csw_dm_tester.sv
module csw_dm_tester
  import csw_init_pkg::*;
#(
  parameter int DM_AW = 8,
  parameter int CW    = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               busy,
  input  op_e                op,
  input  logic [CW-1:0]      cnt,
  output logic               dm_we,
  output logic [DM_AW-1:0]   dm_addr,
  output logic [2*DM_AW-1:0] dm_wdata,
  input  logic [2*DM_AW-1:0] dm_rdata,
  output logic               mismatch,
  output logic               fail
);
  localparam int DW      = 2 * DM_AW;
  localparam int HALF_AW = DM_AW - 1;
  localparam int SPAN    = 4 << HALF_AW;

  function automatic logic [DW-1:0] word_pat(input logic [DM_AW-1:0] a);
    return {a, ~a};
  endfunction

  logic [1:0]         phase;
  logic               active;
  logic [DW-1:0]      pat;
  logic               chk_q;
  logic [DW-1:0]      exp_q;

  assign active   = busy && is_test(op) && (cnt < CW'(SPAN));
  assign phase    = cnt[1:0];
  assign dm_addr  = {op == OP_TEST_UP, cnt[HALF_AW+1:2]};
  assign pat      = phase[1] ? ~word_pat(dm_addr) : word_pat(dm_addr);
  assign dm_we    = active && !phase[0];
  assign dm_wdata = pat;
  assign mismatch = chk_q && (dm_rdata != exp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_q <= 1'b0;
      exp_q <= '0;
      fail  <= 1'b0;
    end else begin
      chk_q <= active && phase[0];
      exp_q <= pat;
      if (start)         fail <= 1'b0;
      else if (mismatch) fail <= 1'b1;
    end
  end

endmodule

// File: rtl/csw_init_seq.sv
module csw_init_seq
  import csw_init_pkg::*;
#(
  parameter int CM_AW       = 8,
  parameter int CM_W        = 12,
  parameter int DM_AW       = 8,
  parameter int CLR_CYCLES  = 4096,
  parameter int TEST_CYCLES = 10240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [2:0]         cmd_code,
  input  logic               status_rd,
  input  logic               mode_en,
  input  logic [CM_AW-1:0]   cm_rd_addr,
  output logic [CM_W-1:0]    cm_rd_data,
  input  logic [DM_AW-1:0]   dm_rd_addr,
  output logic [2*DM_AW-1:0] dm_rd_data,
  output logic               busy,
  output logic               irq,
  output logic               irq_sticky,
  output logic               st_ok,
  output logic               out_oe
);
  localparam int DW   = 2 * DM_AW;
  localparam int MAXC = (TEST_CYCLES > CLR_CYCLES) ? TEST_CYCLES : CLR_CYCLES;
  localparam int CW   = $clog2(MAXC) + 1;

  logic               start, done, mismatch, test_fail;
  op_e                op;
  logic [CW-1:0]      cnt;
  logic               cm_we;
  logic [CM_AW-1:0]   cm_waddr;
  logic [CM_W-1:0]    cm_wdata;
  logic               dm_we;
  logic [DM_AW-1:0]   dm_seq_addr;
  logic [DW-1:0]      dm_wdata;
  logic [DW-1:0]      dm_seq_rdata;
  logic [1:0][DW-1:0] dm_rd_bus;
  logic [0:0][CM_W-1:0] cm_rd_bus;

  csw_seq_ctrl #(.CLR_CYCLES(CLR_CYCLES), .TEST_CYCLES(TEST_CYCLES), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .status_rd(status_rd), .test_fail(test_fail), .start(start), .done(done),
    .busy(busy), .op(op), .cnt(cnt), .irq(irq), .irq_sticky(irq_sticky), .st_ok(st_ok)
  );

  csw_dm_tester #(.DM_AW(DM_AW), .CW(CW)) u_tst (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .op(op), .cnt(cnt),
    .dm_we(dm_we), .dm_addr(dm_seq_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_seq_rdata), .mismatch(mismatch), .fail(test_fail)
  );

  // Every active cycle of either procedure rewrites one connection entry
  // with the tristate bit set and the routing field cleared.
  assign cm_we    = busy;
  assign cm_waddr = cnt[CM_AW-1:0];
  assign cm_wdata = {1'b1, {(CM_W-1){1'b0}}};

  csw_sync_ram #(.AW(CM_AW), .DW(CM_W), .NRP(1)) u_cm (
    .clk(clk), .we(cm_we), .waddr(cm_waddr), .wdata(cm_wdata),
    .raddr(cm_rd_addr), .rdata(cm_rd_bus)
  );
  assign cm_rd_data = cm_rd_bus[0];

  csw_sync_ram #(.AW(DM_AW), .DW(DW), .NRP(2)) u_dm (
    .clk(clk), .we(dm_we), .waddr(dm_seq_addr), .wdata(dm_wdata),
    .raddr({dm_rd_addr, dm_seq_addr}), .rdata(dm_rd_bus)
  );
  assign dm_seq_rdata = dm_rd_bus[0];
  assign dm_rd_data   = dm_rd_bus[1];

  assign out_oe = mode_en && !busy;

endmodule

// File: rtl/csw_init_seq_chk.sv
module csw_init_seq_chk
  import csw_init_pkg::*;
#(
  parameter int CLR_CYCLES  = 4096,
  parameter int TEST_CYCLES = 10240
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic busy,
  input op_e  op,
  input logic irq,
  input logic irq_sticky,
  input logic status_rd,
  input logic st_ok,
  input logic mismatch,
  input logic test_fail,
  input logic cm_we,
  input logic cm_tri
);
  logic [31:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     len_q <= '0;
    else if (start) len_q <= '0;
    else if (busy)  len_q <= len_q + 1;
  end

  // R2 R4: the final cycle of an operation is its fixed length minus one
  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> len_q == (is_test(op) ? 32'(TEST_CYCLES - 1) : 32'(CLR_CYCLES - 1)));

  p_cm_tri_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |-> cm_tri);

  p_hold_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && op == $past(op)));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (irq && irq_sticky && !busy));

  p_sticky_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !done) |=> !irq_sticky);

  p_fail_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !start) |=> test_fail);

  p_bad_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_test(op) && test_fail) |=> !st_ok);

  p_ok_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && is_test(op)) |=> $stable(st_ok));

endmodule

bind csw_init_seq csw_init_seq_chk #(
  .CLR_CYCLES(CLR_CYCLES), .TEST_CYCLES(TEST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy), .op(op),
  .irq(irq), .irq_sticky(irq_sticky), .status_rd(status_rd), .st_ok(st_ok),
  .mismatch(mismatch), .test_fail(test_fail), .cm_we(cm_we),
  .cm_tri(cm_wdata[CM_W-1])
);

// File: tb/csw_init_seq_tb.sv
module csw_init_seq_tb_top;
  localparam int CM_AW = 8;
  localparam int CM_W  = 12;
  localparam int DM_AW = 8;
  localparam int DW    = 2 * DM_AW;
  localparam int NCLR  = 4096;
  localparam int NTST  = 10240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic status_rd = 1'b0;
  logic mode_en = 1'b0;
  logic [CM_AW-1:0] cm_rd_addr = '0;
  logic [CM_W-1:0]  cm_rd_data;
  logic [DM_AW-1:0] dm_rd_addr = '0;
  logic [DW-1:0]    dm_rd_data;
  logic busy, irq, irq_sticky, st_ok, out_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [DW-1:0] snap [1 << DM_AW];

  csw_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .status_rd(status_rd), .mode_en(mode_en), .cm_rd_addr(cm_rd_addr),
    .cm_rd_data(cm_rd_data), .dm_rd_addr(dm_rd_addr), .dm_rd_data(dm_rd_data),
    .busy(busy), .irq(irq), .irq_sticky(irq_sticky), .st_ok(st_ok), .out_oe(out_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] tested_word(input logic [DM_AW-1:0] a);
    logic [DW-1:0] p;
    p = {a, ~a};
    return ~p;
  endfunction

  task automatic issue(input logic [2:0] code);
    @(negedge clk); cmd_we = 1'b1; cmd_code = code;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  // Counts busy cycles from the negedge after the command edge; optionally
  // strobes status_rd in the final busy cycle.
  task automatic finish_op(input string req, input int exp_len, input bit rd_last,
                           input int mid_code);
    int n = 0;
    while (busy === 1'b1 && n < 20000) begin
      n++;
      if (n == 100 && mid_code >= 0) begin
        cmd_we = 1'b1; cmd_code = 3'(mid_code);
      end else cmd_we = 1'b0;
      if (rd_last && n == exp_len) status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
    end
    cmd_we = 1'b0;
    chk({req, " busy length"}, n, exp_len);
    chk("R7 irq at completion", {31'b0, irq}, 1);
    chk("R7 sticky set", {31'b0, irq_sticky}, 1);
    @(negedge clk);
    chk("R7 irq one cycle", {31'b0, irq}, 0);
  endtask

  task automatic cm_all_tri(input string req);
    int bad = 0;
    cm_rd_addr = '0;
    for (int a = 0; a < (1 << CM_AW); a++) begin
      @(negedge clk);
      if (cm_rd_data[CM_W-1] !== 1'b1) bad++;
      cm_rd_addr = CM_AW'(a + 1);
    end
    chk({req, " tristate entries not set"}, bad, 0);
  endtask

  task automatic take_snap();
    dm_rd_addr = '0;
    for (int a = 0; a < (1 << DM_AW); a++) begin
      @(negedge clk);
      snap[a] = dm_rd_data;
      dm_rd_addr = DM_AW'(a + 1);
    end
  endtask

  task automatic dm_compare(input bit upper_tested);
    int bad = 0;
    dm_rd_addr = '0;
    for (int a = 0; a < (1 << DM_AW); a++) begin
      logic [DW-1:0] e;
      @(negedge clk);
      e = ((a >= (1 << (DM_AW-1))) == upper_tested) ? tested_word(DM_AW'(a)) : snap[a];
      if (dm_rd_data !== e) bad++;
      dm_rd_addr = DM_AW'(a + 1);
    end
    chk("R5 data memory half contents", bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 sticky", {31'b0, irq_sticky}, 0);
    chk("R1 st_ok", {31'b0, st_ok}, 0);
    chk("R1 out_oe", {31'b0, out_oe}, 0);
  endtask

  task automatic t_oe_idle();
    @(negedge clk); mode_en = 1'b1;
    #1 chk("R10 enabled idle", {31'b0, out_oe}, 1);
    @(negedge clk); mode_en = 1'b0;
    #1 chk("R10 disabled", {31'b0, out_oe}, 0);
  endtask

  task automatic t_bad_codes();
    for (int c = 0; c < 8; c += 2) begin
      issue(3'(c));
      chk("R9 invalid code no busy", {31'b0, busy}, 0);
      @(negedge clk);
      chk("R9 invalid code no irq", {31'b0, irq}, 0);
    end
  endtask

  task automatic t_clear();
    mode_en = 1'b1;
    issue(3'b001);
    chk("R10 off while busy", {31'b0, out_oe}, 0);
    finish_op("R2 clear", NCLR, 1'b0, -1);
    chk("R10 back on", {31'b0, out_oe}, 1);
    chk("R6 clear keeps st_ok", {31'b0, st_ok}, 0);
    cm_all_tri("R3");
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R8 sticky cleared by read", {31'b0, irq_sticky}, 0);
  endtask

  task automatic t_test_upper();
    take_snap();
    issue(3'b011);
    finish_op("R4 selftest", NTST, 1'b0, -1);
    chk("R6 pass verdict", {31'b0, st_ok}, 1);
    dm_compare(1'b1);
    cm_all_tri("R4");
  endtask

  task automatic t_busy_ignore();
    take_snap();
    issue(3'b101);
    finish_op("R9 command during busy ignored", NCLR, 1'b0, 3'b111);
    chk("R9 st_ok kept", {31'b0, st_ok}, 1);
    dm_compare(1'b0 ^ 1'b1);
  endtask

  task automatic t_fault_lower();
    force dut_i.dm_seq_rdata = '0;
    issue(3'b111);
    finish_op("R4 faulty selftest", NTST, 1'b1, -1);
    release dut_i.dm_seq_rdata;
    chk("R6 fail verdict", {31'b0, st_ok}, 0);
    chk("R8 set wins over read", {31'b0, irq_sticky}, 1);
    status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R8 cleared after read", {31'b0, irq_sticky}, 0);
    issue(3'b101);
    finish_op("R2 clear after fail", NCLR, 1'b0, -1);
    chk("R6 clear keeps fail", {31'b0, st_ok}, 0);
  endtask

  task automatic t_test_lower();
    take_snap();
    issue(3'b111);
    finish_op("R4 selftest lower", NTST, 1'b0, -1);
    chk("R6 pass after fail", {31'b0, st_ok}, 1);
    dm_compare(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oe_idle();
    t_bad_codes();
    t_clear();
    t_test_upper();
    t_busy_ignore();
    t_fault_lower();
    t_test_lower();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule